// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write Guard

This unit keeps the status byte of a serial non-volatile memory and rules on every write the command engine asks for. The engine hands it one-cycle command strobes (latch set, latch clear, status write, array write), the target array address and the data byte for a status write. A write-protect pin and an internal write-cycle timer complete its inputs. It answers with the status byte as a read would return it, a flag telling whether an array write to the presented address would be taken now, and a busy flag.

Two block-protect bits choose how much of the array, counted down from its highest address, is read-only. The choice is made from the top two address bits, so the address width is a parameter. A protect-enable bit combines with the write-protect pin to freeze the status register. Every accepted write starts a timed internal cycle of a parameterised length. The write-enable latch drops when that cycle ends, so each write needs a fresh latch-set command. The non-volatile bits are ordinary registers that take a reset value from a parameter.

Top module: `eeprom_status_guard`

## Requirements
- R1: With no write cycle running, the status byte reads bit 7 = protect-enable, bits 6..4 = 0, bits 3..2 = block-protect level (bit 3 high-order), bit 1 = write-enable latch, bit 0 = 0.
- R2: While a write cycle runs, the status byte reads 8'hFF.
- R3: After synchronous reset the write-enable latch is 0, no cycle runs, and protect-enable and the block-protect level take the parameter NV_RESET (bit 2 = protect-enable, bits 1..0 = level). With the default of 0 the status byte reads 8'h00.
- R4: A latch-set strobe sets the write-enable latch and a latch-clear strobe clears it, whatever the write-protect pin does.
- R5: An array write is taken only if the latch is 1, no cycle runs and the address is outside the protected range. For level 00 nothing is protected. For 01 the top two address bits are 11. For 10 the top address bit is 1. For 11 every address is protected. wr_allow shows this decision for the presented address.
- R6: A status write is taken only if the latch is 1, no cycle runs and the register is not locked. It is locked when wp_n is 0 and protect-enable is 1. A taken write loads protect-enable from data bit 7 and the level from data bits 3..2, and ignores the other data bits.
- R7: A taken write raises busy on the next clock, and busy stays high for exactly WCYC cycles.
- R8: The write-enable latch is 0 once the cycle of a taken write has ended.
- R9: A rejected write starts no cycle and changes neither the latch, the level nor protect-enable.
- R10: Every strobe that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wren | input | 1 | Latch-set strobe |
| cmd_wrdi | input | 1 | Latch-clear strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| cmd_write | input | 1 | Array write strobe |
| wr_addr | input | AW | Array address of the write |
| sr_wdata | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin, low means protect |
| status_byte | output | 8 | Status byte as read |
| wr_allow | output | 1 | Array write to wr_addr would be taken |
| busy | output | 1 | Internal write cycle running |

## Verification
The hardest state to reach is the status-register lock. Protect-enable must first be set through a status write taken while wp_n is high. That write's timed cycle must run out, the latch must be set again, and only then can wp_n be dropped to try the locked write. The bench follows that order, then clears the latch with wp_n still low. It also sends strobes inside busy windows to show they have no effect, and probes the addresses on each side of every protection boundary.

// File: rtl/sr_guard_pkg.sv
// Shared types and the address-range rule for the status/write guard.
// Assumes the array address is at least two bits wide.
package sr_guard_pkg;
    typedef logic [1:0] bp_level_t;

    // Is the segment that the top two address bits select protected at this level?
    function automatic logic seg_protected(input bp_level_t lvl, input logic [1:0] top2);
        case (lvl)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/sr_prot_map.sv
// Decodes protection: tells whether the write address is in the protected
// range and whether the pin and the enable bit together lock the status register.
// Purely combinational. Assumes AW >= 2.
module sr_prot_map
    import sr_guard_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic [AW-1:0] addr,
    input  bp_level_t     lvl,
    input  logic          wpen,
    input  logic          wp_n,
    output logic          hit,
    output logic          hw_lock
);
    localparam int TOP = AW - 1;

    // Compare the top two address bits against the chosen level.
    always_comb begin
        hit     = seg_protected(lvl, addr[TOP -: 2]);
        hw_lock = wpen && !wp_n;
    end
endmodule

// File: rtl/sr_wr_timer.sv
// Timed internal write cycle: a start pulse loads WCYC, and the count runs
// down to zero. busy is high for exactly WCYC cycles, and last marks the final one.
// Assumes start is raised only while idle.
module sr_wr_timer #(
    parameter int WCYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = $clog2(WCYC + 1);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(WCYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Decode the busy and last-cycle flags from the count.
    always_comb begin
        busy = cnt != '0;
        last = cnt == CW'(1);
    end

    p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy)
        else $error("start while busy");
    p_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy)
        else $error("busy did not rise");
endmodule

// File: rtl/sr_state.sv
// Holds the write-enable latch, the block-protect level and protect-enable.
// Decides whether each write strobe is taken. Ignores strobes while busy,
// and clears the latch on the last cycle of a write. Assumes one strobe per cycle.
module sr_state
    import sr_guard_pkg::*;
#(
    parameter logic [2:0] NV_RESET = 3'b000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wren,
    input  logic       cmd_wrdi,
    input  logic       cmd_wrsr,
    input  logic       cmd_write,
    input  logic [7:0] sr_wdata,
    input  logic       busy,
    input  logic       last,
    input  logic       hit,
    input  logic       hw_lock,
    output logic       wel,
    output bp_level_t  lvl,
    output logic       wpen,
    output logic       start
);
    logic sr_take;
    logic arr_take;

    // Accept decision for the two write kinds.
    always_comb begin
        sr_take  = cmd_wrsr  && wel && !busy && !hw_lock;
        arr_take = cmd_write && wel && !busy && !hit;
        start    = sr_take || arr_take;
    end

    // Write-enable latch: set/clear while idle, drop at the end of a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wel <= 1'b0;
        else if (busy) begin
            if (last)
                wel <= 1'b0;
        end else if (cmd_wrdi)
            wel <= 1'b0;
        else if (cmd_wren)
            wel <= 1'b1;
    end

    // Non-volatile bits, loaded by a taken status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wpen <= NV_RESET[2];
            lvl  <= NV_RESET[1:0];
        end else if (sr_take) begin
            wpen <= sr_wdata[7];
            lvl  <= sr_wdata[3:2];
        end
    end

    p_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wren, cmd_wrdi, cmd_wrsr, cmd_write}))
        else $error("more than one strobe");
    p_wel_end_r8: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !wel)
        else $error("latch survived write cycle");
    p_wrdi_r4: assert property (@(posedge clk) disable iff (!rst_n) (cmd_wrdi && !busy) |=> !wel)
        else $error("latch-clear ignored");
endmodule

// File: rtl/eeprom_status_guard.sv
// Top of the status register and write guard. Joins the protection decoder,
// the state registers and the write-cycle timer, and forms the status byte.
// Assumes the command engine raises at most one strobe per cycle.
module eeprom_status_guard
    import sr_guard_pkg::*;
#(
    parameter int         AW       = 15,
    parameter int         WCYC     = 8,
    parameter logic [2:0] NV_RESET = 3'b000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wren,
    input  logic          cmd_wrdi,
    input  logic          cmd_wrsr,
    input  logic          cmd_write,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    sr_wdata,
    input  logic          wp_n,
    output logic [7:0]    status_byte,
    output logic          wr_allow,
    output logic          busy
);
    logic      wel, wpen, hit, hw_lock, start, last;
    bp_level_t lvl;

    sr_prot_map #(.AW(AW)) u_map (
        .addr(wr_addr), .lvl(lvl), .wpen(wpen), .wp_n(wp_n),
        .hit(hit), .hw_lock(hw_lock)
    );

    sr_state #(.NV_RESET(NV_RESET)) u_state (
        .clk(clk), .rst_n(rst_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .cmd_write(cmd_write),
        .sr_wdata(sr_wdata), .busy(busy), .last(last),
        .hit(hit), .hw_lock(hw_lock),
        .wel(wel), .lvl(lvl), .wpen(wpen), .start(start)
    );

    sr_wr_timer #(.WCYC(WCYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .last(last)
    );

    // Status byte as read, and the array-write permission for wr_addr.
    always_comb begin
        status_byte = busy ? 8'hFF : {wpen, 3'b000, lvl, wel, 1'b0};
        wr_allow    = wel && !busy && !hit;
    end

    p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && !wp_n && wpen) |=> $stable({wpen, lvl}))
        else $error("locked status register changed");
    p_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_write && hit && !busy) |=> !busy)
        else $error("protected write started a cycle");
    p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_write && !wel && !busy) |=> (!busy && !wel))
        else $error("write without latch was taken");
endmodule

// File: tb/eeprom_status_guard_tb_top.sv
module eeprom_status_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 15;
    localparam int WCYC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] sr_wdata = '0;
    logic wp_n = 1'b1;
    logic [7:0] status_byte;
    logic wr_allow, busy;

    int checks = 0, fails = 0, cycles = 0;
    bit finished = 0;

    // Reference model state
    int m_wel = 0, m_bp = 0, m_wpen = 0, m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_status_guard #(.AW(AW), .WCYC(WCYC), .NV_RESET(3'b000)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .cmd_write(cmd_write), .wr_addr(wr_addr),
        .sr_wdata(sr_wdata), .wp_n(wp_n), .status_byte(status_byte),
        .wr_allow(wr_allow), .busy(busy)
    );

    function automatic int m_hit(input int bp, input int addr);
        int top = (addr >> (AW - 2)) & 3;
        case (bp)
            0: return 0;
            1: return (top == 3) ? 1 : 0;
            2: return (top >= 2) ? 1 : 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_status();
        if (m_cnt > 0) return 8'hFF;
        return (m_wpen << 7) | (m_bp << 2) | (m_wel << 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, updated on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_wel = 0; m_bp = 0; m_wpen = 0; m_cnt = 0;
        end else if (m_cnt > 0) begin
            if (m_cnt == 1) m_wel = 0;
            m_cnt--;
        end else if (cmd_wrdi) m_wel = 0;
        else if (cmd_wren) m_wel = 1;
        else if (cmd_wrsr) begin
            if (m_wel == 1 && !(wp_n == 0 && m_wpen == 1)) begin
                m_bp = sr_wdata[3:2]; m_wpen = sr_wdata[7]; m_cnt = WCYC;
            end
        end else if (cmd_write) begin
            if (m_wel == 1 && m_hit(m_bp, wr_addr) == 0) m_cnt = WCYC;
        end
    end

    // Compare on every falling edge once out of reset.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(status_byte == 8'(exp_status()), (m_cnt > 0) ? "R2 status" : "R1 status",
                status_byte, exp_status());
            chk(busy == (m_cnt > 0), "R7 busy", busy, m_cnt > 0);
            chk(wr_allow == (m_wel == 1 && m_cnt == 0 && m_hit(m_bp, wr_addr) == 0),
                "R5 wr_allow", wr_allow, (m_wel == 1 && m_cnt == 0 && m_hit(m_bp, wr_addr) == 0));
        end
    end

    task automatic strobe(input int kind, input int addr, input int data);
        @(negedge clk); #1;
        wr_addr = AW'(addr); sr_wdata = 8'(data);
        cmd_wren = (kind == 0); cmd_wrdi = (kind == 1);
        cmd_wrsr = (kind == 2); cmd_write = (kind == 3);
        @(negedge clk); #1;
        cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_write = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic look(input int addr);
        @(negedge clk); #1; wr_addr = AW'(addr); @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        wait (cycles > 200000);
        chk(0, "watchdog", cycles, 200000);
        finish_run();
    end

    initial begin
        int bc;
        idle(3); #1; rst_n = 1;
        @(negedge clk);
        chk(status_byte == 8'h00 && !busy, "R3 reset status", status_byte, 0);

        // R9: array write with latch clear is rejected
        strobe(3, 'h0100, 0); idle(2);
        chk(!busy && status_byte == 8'h00, "R9 rejected write", status_byte, 0);

        // R4: latch set, then array write, count busy length (R7), latch drops (R8)
        strobe(0, 0, 0);
        chk(status_byte == 8'h02, "R4 latch set", status_byte, 8'h02);
        @(negedge clk); #1; wr_addr = AW'('h1234); cmd_write = 1;
        @(negedge clk); #1; cmd_write = 0;
        bc = 0;
        while (busy) begin bc++; @(negedge clk); end
        chk(bc == WCYC, "R7 busy length", bc, WCYC);
        chk(status_byte == 8'h00, "R8 latch cleared after cycle", status_byte, 0);

        // R6: status write sets protect-enable and level 01; noise bits ignored
        strobe(0, 0, 0); strobe(2, 0, 'hF4); idle(1);
        chk(status_byte == 8'hFF, "R2 busy status", status_byte, 8'hFF);
        idle(WCYC);
        chk(status_byte == 8'h84, "R6 status loaded", status_byte, 8'h84);

        // R5: boundary at level 01
        strobe(0, 0, 0);
        look('h6000); chk(!wr_allow, "R5 top quarter protected", wr_allow, 0);
        look('h5FFF); chk(wr_allow, "R5 below top quarter open", wr_allow, 1);
        strobe(3, 'h6000, 0); idle(1);
        chk(!busy && status_byte == 8'h86, "R9 protected write rejected", status_byte, 8'h86);
        strobe(3, 'h5FFF, 0); idle(1);
        // R10: status write inside the busy window is ignored
        strobe(2, 0, 'h0C); idle(WCYC);
        chk(status_byte == 8'h84, "R10 strobe while busy ignored", status_byte, 8'h84);

        // R6 lock: pin low with protect-enable set
        strobe(0, 0, 0);
        @(negedge clk); #1; wp_n = 0;
        strobe(2, 0, 'h08); idle(2);
        chk(!busy && status_byte == 8'h86, "R6 locked status write rejected", status_byte, 8'h86);
        strobe(1, 0, 0);
        chk(status_byte == 8'h84, "R4 latch clear with pin low", status_byte, 8'h84);

        // Unlock, choose level 10
        @(negedge clk); #1; wp_n = 1;
        strobe(0, 0, 0); strobe(2, 0, 'h08); idle(WCYC + 1);
        chk(status_byte == 8'h08, "R6 level 10 loaded", status_byte, 8'h08);
        strobe(0, 0, 0);
        look('h4000); chk(!wr_allow, "R5 top half protected", wr_allow, 0);
        look('h3FFF); chk(wr_allow, "R5 lower half open", wr_allow, 1);
        // pin low but protect-enable 0: not locked, choose level 11
        @(negedge clk); #1; wp_n = 0;
        strobe(2, 0, 'h0C); idle(WCYC + 1);
        chk(status_byte == 8'h0C, "R6 pin alone does not lock", status_byte, 8'h0C);
        strobe(0, 0, 0);
        look('h0000); chk(!wr_allow, "R5 whole array protected", wr_allow, 0);
        strobe(3, 'h0000, 0); idle(2);
        chk(!busy && status_byte == 8'h0E, "R9 latch kept after reject", status_byte, 8'h0E);
        strobe(1, 0, 0); idle(2);
        chk(status_byte == 8'h0C, "R4 final clear", status_byte, 8'h0C);
        finish_run();
    end
endmodule